// File: doc/BRIEF.md
# Two-Wire Register-Access Target

This block is the target (slave) side of a two-wire serial bus, built to give an outside host byte-wide access to a block's register space. SCL and SDA arrive as raw pad levels. They are brought into the system clock domain, which runs far faster than the bus, and edge detection on the synchronised levels yields the bus conditions. The engine answers only to its own 7-bit device address, which defaults to 0x58. After the address it takes one pointer byte. It then either writes one register or, after a repeated start, returns one register to the host.

The SDA output is open-drain. The block produces only an enable: while the enable is high, the pad pulls SDA low. The register side is a simple port with an address, write data, a write strobe, read data and a read strobe. The address output always shows the current pointer. Read data must be valid combinationally in the cycle in which the read strobe is high.

Top module: `regbus_i2c_target`

## Requirements
- R1: A start condition (SDA falling while SCL is high) or a stop condition (SDA rising while SCL is high) ends any transfer in progress. A stop returns the block to idle with SDA released. After a stop, no byte is acknowledged and no register is written until the next start.
- R2: The first byte after a start is taken MSB first. Its upper seven bits are the device address and bit 0 is the direction (1 = read, 0 = write). When the address equals DEV_ADDR, the block holds SDA low during the ninth clock.
- R3: When the address does not match, SDA stays released during the ninth clock. No later byte is acknowledged and no strobe is issued until the next start.
- R4: In a write transfer the second byte is acknowledged and becomes the pointer, which then appears on `reg_addr`. The third byte is acknowledged, and exactly one `reg_we` pulse is issued with `reg_wdata` equal to that byte and `reg_addr` equal to the pointer.
- R5: After a repeated start with the read bit set, exactly one `reg_re` pulse is issued with `reg_addr` equal to the pointer. The byte on `reg_rdata` is then sent MSB first: a 0 bit drives SDA low and a 1 bit releases it.
- R6: During the host's acknowledge clock after the read byte, and afterwards, SDA is released.
- R7: The SDA enable changes only while the synchronised SCL is low. It is stable through every SCL high phase.
- R8: The active-low asynchronous reset releases SDA, clears both strobes and clears the pointer to 0x00.
- R9: A start that arrives partway through a byte throws away the partial byte. The bits that follow are framed as a new address byte.
- R10: Only one data byte is accepted per write transfer. Any further bytes are not acknowledged and do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 = pull SDA low; 0 = release |
| reg_addr | output | 8 | Register pointer (register address) |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data, valid combinationally while reg_re is high |
| reg_re | output | 1 | One-cycle read strobe |

## Verification
A wrong bit count or phase in the engine shows at the pad within one SCL clock. The SDA enable is then either wrong during an SCL high phase or missing or present on the ninth clock, so the bench compares the enable with its own bus model on every system clock of every high phase. A wrong pointer shows immediately on `reg_addr` and in the address that goes with each strobe. A missing or extra strobe shows in the very cycle it fires, because the bench expects each strobe only inside a window that its model opens.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_PTR,
        PH_PTR_ACK,
        PH_WDATA,
        PH_WDATA_ACK,
        PH_LOAD,
        PH_TX,
        PH_HOST_ACK
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_s;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                rw;
        logic [BYTE_W-1:0]   ptr;
        logic [BYTE_W-1:0]   wdata;
        logic                oe;
        logic                we;
    } eng_s;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign dout[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond
    import i2ct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    line_s prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  =  scl_s && !prev_q.scl;
    assign scl_fall  = !scl_s &&  prev_q.scl;
    assign start_det =  scl_s &&  prev_q.scl &&  prev_q.sda && !sda_s;
    assign stop_det  =  scl_s &&  prev_q.scl && !prev_q.sda &&  sda_s;

    // R1: the four events never coincide
    p_events_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_det, stop_det}));

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rdata,
    output logic              oe,
    output logic [BYTE_W-1:0] ptr,
    output logic [BYTE_W-1:0] wdata,
    output logic              we,
    output logic              re
);

    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);

    eng_s d, q;
    logic byte_done;

    assign byte_done = scl_fall && (q.cnt == FULL_BYTE);

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_det) begin
            d.phase = PH_IDLE;
            d.oe    = 1'b0;
        end else if (start_det) begin
            d.phase = PH_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else begin
            unique case (q.phase)
                PH_ADDR, PH_PTR, PH_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (byte_done) begin
                        d.oe = 1'b1;
                        if (q.phase == PH_ADDR) begin
                            if (q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                                d.rw    = q.sh[0];
                                d.phase = PH_ADDR_ACK;
                            end else begin
                                d.oe    = 1'b0;
                                d.phase = PH_IDLE;
                            end
                        end else if (q.phase == PH_PTR) begin
                            d.ptr   = q.sh;
                            d.phase = PH_PTR_ACK;
                        end else begin
                            d.wdata = q.sh;
                            d.we    = 1'b1;
                            d.phase = PH_WDATA_ACK;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.cnt   = '0;
                        d.phase = q.rw ? PH_LOAD : PH_PTR;
                    end
                end
                PH_PTR_ACK: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.cnt   = '0;
                        d.phase = PH_WDATA;
                    end
                end
                PH_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.phase = PH_IDLE;
                    end
                end
                PH_LOAD: begin
                    d.sh    = rdata;
                    d.oe    = !rdata[BYTE_W-1];
                    d.cnt   = '0;
                    d.phase = PH_TX;
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe    = 1'b0;
                            d.phase = PH_HOST_ACK;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = !q.sh[BYTE_W-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_HOST_ACK: begin
                    if (scl_fall) d.phase = PH_IDLE;
                end
                default: d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, sh: '0, rw: 1'b0,
                   ptr: '0, wdata: '0, oe: 1'b0, we: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign oe    = q.oe;
    assign ptr   = q.ptr;
    assign wdata = q.wdata;
    assign we    = q.we;
    assign re    = (q.phase == PH_LOAD);

    // R7: the output never moves while SCL stays high
    p_sda_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(q.oe));

    // R1: a stop always leaves SDA released
    p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !q.oe);

    // R4: the write strobe lasts one cycle
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    // R5: the first transmitted bit follows the fetched MSB
    p_load_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> (q.oe == !$past(rdata[BYTE_W-1])));

    // R3: a foreign address never gets an acknowledge
    p_no_ack_foreign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_ADDR && byte_done && q.sh[BYTE_W-1:1] != DEV_ADDR
         && !start_det && !stop_det) |=> !q.oe);

    // R8: reset leaves the pointer clear and SDA released
    always @(posedge clk) begin
        if (rst_n && $past(!rst_n)) begin
            p_reset_state_r8: assert (q.ptr == '0 && !q.oe);
        end
    end

endmodule

// File: rtl/regbus_i2c_target.sv
module regbus_i2c_target
    import i2ct_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h58,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata,
    output logic       reg_re
);

    logic [1:0] raw_lines;
    logic [1:0] sync_lines;
    logic       scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {scl_i, sda_i};

    i2ct_sync #(.STAGES(SYNC_STAGES), .W(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lines),
        .dout  (sync_lines)
    );

    i2ct_cond i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (sync_lines[1]),
        .sda_s     (sync_lines[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2ct_engine #(.DEV_ADDR(DEV_ADDR)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (sync_lines[1]),
        .sda_lvl   (sync_lines[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (reg_rdata),
        .oe        (sda_oe),
        .ptr       (reg_addr),
        .wdata     (reg_wdata),
        .we        (reg_we),
        .re        (reg_re)
    );

endmodule

// File: tb/test_regbus_i2c_target.sv
`timescale 1ns/1ps
module test_regbus_i2c_target;

    localparam int Q = 12;
    localparam logic [6:0] DEV = 7'h58;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;
    logic       exp_oe = 1'b0;
    logic       we_pend = 1'b0;
    logic [7:0] we_addr = 8'h00, we_data = 8'h00;
    logic       re_pend = 1'b0;
    string      cur_tag = "R8";
    int         vectors = 0;
    int         miscompares = 0;
    int         cycles = 0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    regbus_i2c_target i_regbus_i2c_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .reg_re    (reg_re)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // per-clock comparison against the bus model
    always @(posedge clk) begin
        #1;
        cycles++;
        if (rst_n) begin
            if (scl_m) chk(sda_oe == exp_oe, cur_tag, "sda_oe in high phase", sda_oe, exp_oe);
            if (reg_we) begin
                chk(we_pend && reg_addr == we_addr && reg_wdata == we_data,
                    cur_tag, "write strobe", {reg_addr, reg_wdata}, {we_addr, we_data});
                mem[reg_addr] = reg_wdata;
                we_pend = 1'b0;
            end
            if (reg_re) begin
                chk(re_pend && reg_addr == exp_ptr, cur_tag, "read strobe", reg_addr, exp_ptr);
                re_pend = 1'b0;
            end
        end
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_out(input logic b, input logic oe_expect, output logic s);
        exp_oe = 1'b0;
        sda_m = b;
        wq();
        exp_oe = oe_expect;
        scl_m = 1'b1;
        wq();
        s = sda_line;
        wq();
        scl_m = 1'b0;
        exp_oe = 1'b0;
        wq();
    endtask

    task automatic bus_start();
        exp_oe = 1'b0;
        sda_m = 1'b1;
        wq();
        scl_m = 1'b1;
        wq();
        sda_m = 1'b0;
        wq();
        scl_m = 1'b0;
        wq();
    endtask

    task automatic bus_stop();
        exp_oe = 1'b0;
        sda_m = 1'b0;
        wq();
        scl_m = 1'b1;
        wq();
        sda_m = 1'b1;
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack_exp, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i], 1'b0, s);
        bit_out(1'b1, ack_exp, s);
        chk(s == !ack_exp, tag, "acknowledge level", s, !ack_exp);
    endtask

    task automatic do_write(input logic [7:0] ptr, input logic [7:0] data, input string tag);
        cur_tag = tag;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, tag);
        send_byte(ptr, 1'b1, tag);
        exp_ptr = ptr;
        we_pend = 1'b1; we_addr = ptr; we_data = data;
        send_byte(data, 1'b1, tag);
        exp_mem[ptr] = data;
        bus_stop();
        chk(!we_pend, tag, "write strobe seen", we_pend, 0);
        chk(reg_addr == exp_ptr, tag, "pointer", reg_addr, exp_ptr);
    endtask

    task automatic do_read(input logic [7:0] ptr, input string tag);
        logic [7:0] e, got;
        logic s;
        cur_tag = tag;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, tag);
        send_byte(ptr, 1'b1, tag);
        exp_ptr = ptr;
        bus_start();
        re_pend = 1'b1;
        send_byte({DEV, 1'b1}, 1'b1, tag);
        e = exp_mem[ptr];
        for (int i = 7; i >= 0; i--) begin
            bit_out(1'b1, !e[i], s);
            got[i] = s;
        end
        bit_out(1'b1, 1'b0, s);   // R6: host NACK, target released
        chk(s == 1'b1, "R6", "line during host acknowledge", s, 1);
        bus_stop();
        chk(got == e, tag, "read byte", got, e);
        chk(!re_pend, tag, "read strobe seen", re_pend, 0);
    endtask

    initial begin
        logic s;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h3C;
            exp_mem[i] = 8'(i) ^ 8'h3C;
        end
        repeat (5) @(negedge clk);
        // R8: reset state
        chk(sda_oe == 1'b0, "R8", "sda_oe in reset", sda_oe, 0);
        chk(reg_addr == 8'h00, "R8", "pointer in reset", reg_addr, 0);
        chk(!reg_we && !reg_re, "R8", "strobes in reset", {reg_we, reg_re}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R4: write
        do_write(8'h12, 8'hA5, "R4");
        do_write(8'hFF, 8'h00, "R4");
        // R5: reads, including written and untouched locations
        do_read(8'h12, "R5");
        do_read(8'h40, "R5");
        do_read(8'hFF, "R5");
        do_read(8'h00, "R2");

        // R3: foreign addresses, then data bytes must be ignored
        cur_tag = "R3";
        bus_start();
        send_byte({7'h59, 1'b0}, 1'b0, "R3");
        send_byte(8'h33, 1'b0, "R3");
        send_byte(8'h99, 1'b0, "R3");
        bus_stop();
        chk(reg_addr == exp_ptr, "R3", "pointer untouched", reg_addr, exp_ptr);
        bus_start();
        send_byte({7'h18, 1'b1}, 1'b0, "R3");
        bus_stop();

        // R10: extra data bytes in one write
        cur_tag = "R10";
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R10");
        send_byte(8'h05, 1'b1, "R10");
        exp_ptr = 8'h05;
        we_pend = 1'b1; we_addr = 8'h05; we_data = 8'h6B;
        send_byte(8'h6B, 1'b1, "R10");
        exp_mem[8'h05] = 8'h6B;
        send_byte(8'hC4, 1'b0, "R10");
        send_byte(8'h11, 1'b0, "R10");
        bus_stop();
        chk(mem[8'h05] == 8'h6B, "R10", "stored byte", mem[8'h05], 8'h6B);
        do_read(8'h05, "R10");

        // R9: start inside the pointer byte and inside the address byte
        cur_tag = "R9";
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R9");
        for (int i = 0; i < 3; i++) bit_out(1'b1, 1'b0, s);
        bus_start();
        for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0, s);
        do_write(8'h21, 8'h5E, "R9");
        chk(mem[8'h21] == 8'h5E, "R9", "write after abort", mem[8'h21], 8'h5E);

        // R1: stop inside the pointer byte, then bytes with no start
        cur_tag = "R1";
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R1");
        for (int i = 0; i < 3; i++) bit_out(1'b0, 1'b0, s);
        bus_stop();
        chk(reg_addr == 8'h21, "R1", "pointer after stop", reg_addr, 8'h21);
        chk(sda_oe == 1'b0, "R1", "released after stop", sda_oe, 0);
        scl_m = 1'b0;
        wq();
        send_byte({DEV, 1'b0}, 1'b0, "R1");
        send_byte(8'h44, 1'b0, "R1");
        bus_stop();
        chk(reg_addr == 8'h21, "R1", "pointer idle bus", reg_addr, 8'h21);

        // R7 is compared on every high phase above; R8: reset mid-use
        do_write(8'h77, 8'h3A, "R7");
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(reg_addr == 8'h00, "R8", "pointer cleared", reg_addr, 0);
        chk(sda_oe == 1'b0, "R8", "sda released", sda_oe, 0);
        exp_ptr = 8'h00;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        do_read(8'h77, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule